// File: doc/BRIEF.md
# Set/Clear GPIO Port with Implicit Direction

This block is a general-purpose I/O port with 32 pins on a simple single-cycle register bus. Each pin has an output latch and a driver enable. Software never writes a direction register. It drives pins through a set register and a clear register, which both take one-hot-style masks. Either write also turns on the drivers of the pins it selects. A separate driver-release register returns the selected pins to input mode. The output latch of a released pin keeps its value.

The port does not sample its inputs after reset. A pin-level register reads as zero until software writes once to an arming register. The data of that write is ignored. From then on, the pin-level register returns the pin levels after a two-flop synchronizer. Bus accesses finish in the cycle in which they are presented. Reads are combinational from the registered state.

Registers are addressed by a 3-bit word index:

| Index | Name | Write | Read |
|---|---|---|---|
| 0 | level | no effect | synchronized pin levels |
| 1 | release | turns off drivers | driver enables |
| 2 | set | drives high and enables | output latch |
| 3 | clear | drives low and enables | output latch |
| 4 | arm | arms input sampling | arm flag in bit 0 |
| 5–7 | unmapped | no effect | zero |

Top module: `gpio_sc_port`

## Requirements
- R1: After reset, `pin_oe` and `pin_out` are all zero. The level register (index 0) reads zero and the arm register (index 4) reads zero.
- R2: A write to index 2 (set) makes `pin_out` high for every mask bit that is 1. All other latch bits keep their value.
- R3: A write to index 3 (clear) makes `pin_out` low for every mask bit that is 1. All other latch bits keep their value.
- R4: A write to index 2 or 3 sets `pin_oe` for every mask bit that is 1. All other enable bits keep their value.
- R5: A write to index 1 (release) clears `pin_oe` for every mask bit that is 1. The output latch does not change.
- R6: While the port is unarmed, the level register reads zero whatever is on `pin_in`.
- R7: Any write to index 4 arms the port, whatever its data. Once armed, a change on `pin_in` is visible in the level register after two rising clock edges, and not after one.
- R8: A read of index 2 or 3 returns the output latch. A read of index 1 returns the driver enables. A read of index 4 returns the arm flag in bit 0, with the other bits zero.
- R9: `bus_ready` equals `bus_sel` in the same cycle. `bus_rdata` is zero whenever no read is selected.
- R10: A write to index 0 or to indices 5–7 changes neither `pin_out` nor `pin_oe`. A read of indices 5–7 returns zero.
- R11: Once armed, the port stays armed until reset. A further arm write has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data / pin mask |
| bus_rdata | output | 32 | Read data |
| bus_ready | output | 1 | Access completes this cycle |
| pin_in | input | 32 | Pin levels from pads |
| pin_out | output | 32 | Output latch to pads |
| pin_oe | output | 32 | Driver enable to pads |

## Verification
The hardest state to reach is the arming boundary. The stimulus holds a non-zero pattern on the pins for several cycles before arming, to show that nothing leaks into the synchronizer. It then arms the port and changes the pins on a falling edge. The level register is read after one rising edge and again after two, which exposes a missing or extra synchronizer stage.

The interaction of the release register with the latch is reached by first setting and clearing overlapping masks. Selected drivers are then released, and the bench confirms through the set register that the latch did not move.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;

    parameter int GPIO_PINS = 32;
    parameter int REG_IDX_W = 3;

    typedef enum logic [2:0] {
        REG_LEVEL   = 3'd0,
        REG_RELEASE = 3'd1,
        REG_SET     = 3'd2,
        REG_CLEAR   = 3'd3,
        REG_ARM     = 3'd4
    } reg_idx_e;

    typedef struct packed {
        logic set;
        logic clr;
        logic rel;
        logic arm;
    } wr_stb_t;

endpackage

// File: rtl/gpio_sc_regdec.sv
module gpio_sc_regdec
    import gpio_sc_pkg::*;
#(
    parameter int NPINS = GPIO_PINS,
    parameter int IDX_W = REG_IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [IDX_W-1:0] bus_addr,
    input  logic [NPINS-1:0] bus_wdata,
    input  logic [NPINS-1:0] latch_i,
    input  logic [NPINS-1:0] drive_i,
    input  logic [NPINS-1:0] level_i,
    input  logic             armed_i,
    output wr_stb_t          stb_o,
    output logic [NPINS-1:0] mask_o,
    output logic [NPINS-1:0] rdata_o,
    output logic             ready_o
);

    logic wr_go;
    logic rd_go;

    always_comb begin
        wr_go = bus_sel && bus_wr;
        rd_go = bus_sel && !bus_wr;
    end

    // Write strobes: at most one register per access
    always_comb begin
        stb_o  = '0;
        mask_o = bus_wdata;
        if (wr_go) begin
            case (bus_addr)
                IDX_W'(REG_SET):     stb_o.set = 1'b1;
                IDX_W'(REG_CLEAR):   stb_o.clr = 1'b1;
                IDX_W'(REG_RELEASE): stb_o.rel = 1'b1;
                IDX_W'(REG_ARM):     stb_o.arm = 1'b1;
                default:             stb_o     = '0;
            endcase
        end
    end

    // Read mux
    always_comb begin
        rdata_o = '0;
        if (rd_go) begin
            case (bus_addr)
                IDX_W'(REG_LEVEL):   rdata_o = level_i;
                IDX_W'(REG_RELEASE): rdata_o = drive_i;
                IDX_W'(REG_SET):     rdata_o = latch_i;
                IDX_W'(REG_CLEAR):   rdata_o = latch_i;
                IDX_W'(REG_ARM):     rdata_o = {{(NPINS-1){1'b0}}, armed_i};
                default:             rdata_o = '0;
            endcase
        end
    end

    always_comb ready_o = bus_sel;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(stb_o) <= 1); // R10

    AST_READ_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |-> (stb_o == '0)); // R9

endmodule

// File: rtl/gpio_sc_pinbank.sv
module gpio_sc_pinbank
    import gpio_sc_pkg::*;
#(
    parameter int NPINS = GPIO_PINS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wr_stb_t          stb_i,
    input  logic [NPINS-1:0] mask_i,
    output logic [NPINS-1:0] latch_o,
    output logic [NPINS-1:0] drive_o
);

    typedef struct packed {
        logic [NPINS-1:0] latch;
        logic [NPINS-1:0] drive;
    } bank_t;

    bank_t bank_d;
    bank_t bank_q;

    always_comb begin
        bank_d = bank_q;
        if (stb_i.rel) begin
            bank_d.drive = bank_d.drive & ~mask_i;
        end
        if (stb_i.set) begin
            bank_d.latch = bank_d.latch | mask_i;
            bank_d.drive = bank_d.drive | mask_i;
        end
        // clear evaluated last so it wins over set
        if (stb_i.clr) begin
            bank_d.latch = bank_d.latch & ~mask_i;
            bank_d.drive = bank_d.drive | mask_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    always_comb begin
        latch_o = bank_q.latch;
        drive_o = bank_q.drive;
    end

    AST_SET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i.set && !stb_i.clr) |=> ((latch_o & $past(mask_i)) == $past(mask_i))); // R2

    AST_CLR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        stb_i.clr |=> ((latch_o & $past(mask_i)) == '0)); // R3

    AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i.set || stb_i.clr) |=> ((drive_o & $past(mask_i)) == $past(mask_i))); // R4

    AST_RELEASE_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i.rel && !stb_i.set && !stb_i.clr) |=> ((drive_o & $past(mask_i)) == '0)); // R5

    AST_RELEASE_KEEPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i.rel && !stb_i.set && !stb_i.clr) |=> $stable(latch_o)); // R5

endmodule

// File: rtl/gpio_sc_insync.sv
module gpio_sc_insync
    import gpio_sc_pkg::*;
#(
    parameter int NPINS = GPIO_PINS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic [NPINS-1:0] pin_i,
    output logic [NPINS-1:0] level_o,
    output logic             armed_o
);

    typedef struct packed {
        logic             armed;
        logic [NPINS-1:0] meta;
        logic [NPINS-1:0] sync;
    } smp_t;

    smp_t smp_d;
    smp_t smp_q;

    always_comb begin
        smp_d = smp_q;
        if (arm_i) begin
            smp_d.armed = 1'b1;
        end
        if (smp_q.armed) begin
            smp_d.meta = pin_i;
            smp_d.sync = smp_q.meta;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= '0;
        end else begin
            smp_q <= smp_d;
        end
    end

    always_comb begin
        level_o = smp_q.sync;
        armed_o = smp_q.armed;
    end

    AST_UNARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_o |-> (smp_q.meta == '0 && level_o == '0)); // R6

    AST_ARM_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> armed_o); // R7

    AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        armed_o |=> armed_o); // R11

endmodule

// File: rtl/gpio_sc_port.sv
module gpio_sc_port
    import gpio_sc_pkg::*;
#(
    parameter int NPINS = GPIO_PINS,
    parameter int IDX_W = REG_IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [IDX_W-1:0] bus_addr,
    input  logic [NPINS-1:0] bus_wdata,
    output logic [NPINS-1:0] bus_rdata,
    output logic             bus_ready,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe
);

    wr_stb_t          stb;
    logic [NPINS-1:0] mask;
    logic [NPINS-1:0] latch;
    logic [NPINS-1:0] drive;
    logic [NPINS-1:0] level;
    logic             armed;

    gpio_sc_regdec #(.NPINS(NPINS), .IDX_W(IDX_W)) i_regdec (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .latch_i   (latch),
        .drive_i   (drive),
        .level_i   (level),
        .armed_i   (armed),
        .stb_o     (stb),
        .mask_o    (mask),
        .rdata_o   (bus_rdata),
        .ready_o   (bus_ready)
    );

    gpio_sc_pinbank #(.NPINS(NPINS)) i_pinbank (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb_i   (stb),
        .mask_i  (mask),
        .latch_o (latch),
        .drive_o (drive)
    );

    gpio_sc_insync #(.NPINS(NPINS)) i_insync (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_i   (stb.arm),
        .pin_i   (pin_in),
        .level_o (level),
        .armed_o (armed)
    );

    always_comb begin
        pin_out = latch;
        pin_oe  = drive;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |-> (bus_rdata == '0 && !bus_ready)); // R9

    AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr) |=> ($stable(pin_out) && $stable(pin_oe))); // R10

endmodule

// File: tb/test_gpio_sc_port.sv
module test_gpio_sc_port;

    localparam int NP = 32;
    localparam int NV = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic [NP-1:0] bus_wdata = '0;
    logic [NP-1:0] bus_rdata;
    logic          bus_ready;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_sc_port i_gpio_sc_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ready (bus_ready),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    // {write, index, value, requirement number}
    localparam logic [39:0] VEC [NV] = '{
        {1'b1, 3'd2, 32'h0000_00FF, 4'd2},
        {1'b0, 3'd2, 32'h0000_00FF, 4'd2},  // R2
        {1'b0, 3'd1, 32'h0000_00FF, 4'd4},  // R4
        {1'b1, 3'd3, 32'h0000_000F, 4'd3},
        {1'b0, 3'd3, 32'h0000_00F0, 4'd3},  // R3 R8
        {1'b0, 3'd1, 32'h0000_00FF, 4'd4},  // R4
        {1'b1, 3'd2, 32'hF000_0000, 4'd2},
        {1'b0, 3'd2, 32'hF000_00F0, 4'd2},  // R2
        {1'b0, 3'd1, 32'hF000_00FF, 4'd4},  // R4
        {1'b1, 3'd1, 32'h0000_00F0, 4'd5},
        {1'b0, 3'd1, 32'hF000_000F, 4'd5},  // R5
        {1'b0, 3'd3, 32'hF000_00F0, 4'd5},  // R5 latch kept
        {1'b1, 3'd0, 32'hFFFF_FFFF, 4'd10},
        {1'b1, 3'd6, 32'hFFFF_FFFF, 4'd10},
        {1'b0, 3'd2, 32'hF000_00F0, 4'd10}, // R10
        {1'b0, 3'd7, 32'h0000_0000, 4'd10}, // R10
        {1'b0, 3'd0, 32'h0000_0000, 4'd6}   // R6
    };

    task automatic check(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] idx, input logic [NP-1:0] data);
        @(negedge clk);
        bus_sel   = 1'b1;
        bus_wr    = 1'b1;
        bus_addr  = idx;
        bus_wdata = data;
        @(posedge clk);
        #1;
        bus_sel = 1'b0;
        bus_wr  = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] idx, output logic [NP-1:0] data, output logic rdy);
        @(negedge clk);
        bus_sel  = 1'b1;
        bus_wr   = 1'b0;
        bus_addr = idx;
        #1;
        data = bus_rdata;
        rdy  = bus_ready;
        #1;
        bus_sel = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [NP-1:0] rd;
        logic          rdy;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check("R1 pin_oe", pin_oe, '0);
        check("R1 pin_out", pin_out, '0);
        bus_read(3'd0, rd, rdy);
        check("R1 level", rd, '0);
        bus_read(3'd4, rd, rdy);
        check("R1 arm", rd, '0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][39]) begin
                bus_write(VEC[i][38:36], VEC[i][35:4]);
            end else begin
                bus_read(VEC[i][38:36], rd, rdy);
                check($sformatf("R%0d vec%0d", VEC[i][3:0], i), rd, VEC[i][35:4]);
            end
        end

        // R2 R3 R4 R5 at the pins
        @(negedge clk);
        check("R2 R3 pin_out", pin_out, 32'hF000_00F0);
        check("R4 R5 pin_oe", pin_oe, 32'hF000_000F);

        // R6 pins busy, unarmed
        pin_in = 32'hA5A5_5A5A;
        repeat (5) @(posedge clk);
        bus_read(3'd0, rd, rdy);
        check("R6 level unarmed", rd, '0);

        // R7 arm with zero data
        bus_write(3'd4, 32'h0);
        bus_read(3'd4, rd, rdy);
        check("R7 R8 arm flag", rd, 32'h1);
        repeat (2) @(posedge clk);
        bus_read(3'd0, rd, rdy);
        check("R7 level armed", rd, 32'hA5A5_5A5A);

        // R7 two-edge latency
        @(negedge clk);
        pin_in = 32'h1234_5678;
        @(posedge clk);
        bus_read(3'd0, rd, rdy);
        check("R7 one edge old", rd, 32'hA5A5_5A5A);
        @(posedge clk);
        bus_read(3'd0, rd, rdy);
        check("R7 two edges new", rd, 32'h1234_5678);

        // R11 re-arm
        bus_write(3'd4, 32'hFFFF_FFFF);
        bus_read(3'd4, rd, rdy);
        check("R11 still armed", rd, 32'h1);

        // R9 ready and idle bus
        bus_read(3'd2, rd, rdy);
        check("R9 ready on read", {31'b0, rdy}, 32'h1);
        check("R8 set read", rd, 32'hF000_00F0);
        @(negedge clk);
        #1;
        check("R9 idle ready", {31'b0, bus_ready}, 32'h0);
        check("R9 idle rdata", bus_rdata, '0);

        // R3 clear re-enables released pins
        bus_write(3'd3, 32'h0000_00F0);
        @(negedge clk);
        check("R3 pin_out", pin_out, 32'hF000_0000);
        check("R4 pin_oe", pin_oe, 32'hF000_00FF);

        finish_run();
    end

endmodule